// File: doc/BRIEF.md
# Block Lock Write Protection Controller

This block decides, one request at a time, whether a write may proceed. A write can target the 8K-byte memory array or the control register. A write to the array is refused when its address falls in a protected region at the top of the address space. A 3-bit lock code picks the size of that region: a fraction of the array or a fixed number of bytes. A write to the control register is refused in two cases. The first is when the volatile write-enable latch is clear. The second is when the external write-protect pin is high and the register's hardware-lock enable bit is set. When the pin is high and the bit is set, the lock settings are frozen.

The host sends one request per cycle: a kind, an address, a data byte, and the level of the write-protect pin. One cycle later the block answers with a response strobe and a grant bit. Separate commands set and clear the write-enable latch, and these commands are always granted. A granted control write loads the lock code, the watchdog select field and the hardware-lock enable bit from the data byte.

The block has two resets. The factory-clear reset sets the register fields to their default values. The power-on reset clears only the latch and the response, so the register fields survive a power cycle.

Top module: `blk_lock_guard`

## Requirements
- R1: While `nvClrN` is low, `lockCode` reads 000, `wpEnable` reads 0, `wdSel` reads 11, `wel` reads 0 and `respValid` reads 0.
- R2: Every cycle with `reqValid` high is answered by `respValid` high in the next cycle. A cycle with `reqValid` low produces `respValid` low in the next cycle.
- R3: An array request (`reqKind` 00) is denied when `lockCode` is 011 (the whole array). It is denied when the code is 001 and `reqAddr` >= 0x1800, and when the code is 010 and `reqAddr` >= 0x1000. With code 000, no address is denied.
- R4: Codes 100, 101, 110 and 111 protect the top 64, 128, 256 and 512 bytes. An array request is denied at `reqAddr` >= 0x2000 minus that size and granted at the address just below.
- R5: An array request outside the locked region is granted for every combination of `wpPin` and `wpEnable`.
- R6: A latch-set request (`reqKind` 10) or a latch-clear request (11) is always granted. It drives `wel` to 1 or to 0 respectively.
- R7: A control write (`reqKind` 01) is denied while `wel` is 0, and it leaves `lockCode`, `wdSel` and `wpEnable` unchanged.
- R8: A control write is denied when `wpPin` is high and `wpEnable` is 1, and it leaves all fields unchanged. With `wel` at 1 and either of those two low, the write is granted.
- R9: A granted control write loads `lockCode` from data bits [2:0], `wdSel` from bits [4:3] and `wpEnable` from bit 7. `wel` is unchanged.
- R10: A pulse on `porN` clears `wel` and leaves `lockCode`, `wdSel` and `wpEnable` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nvClrN | input | 1 | Async active-low factory clear of the register fields |
| porN | input | 1 | Async active-low power-on reset: latch and response |
| reqValid | input | 1 | Request strobe |
| reqKind | input | 2 | 00 array, 01 control, 10 latch set, 11 latch clear |
| reqAddr | input | 13 | Array byte address |
| reqData | input | 8 | Control register data byte |
| wpPin | input | 1 | External write-protect level |
| respValid | output | 1 | Response strobe, one cycle after the request |
| respGrant | output | 1 | 1 = write allowed |
| wel | output | 1 | Write-enable latch |
| lockCode | output | 3 | Current lock code |
| wpEnable | output | 1 | Hardware-lock enable bit |
| wdSel | output | 2 | Watchdog interval select field |

## Verification
The bench tests each region code at the exact boundary address and at the address just below it. An off-by-one decode, or a swap between the fractional codes and the fixed-size codes, shows up there as a wrong grant. It attempts control writes with the latch clear, and with the pin and the enable bit both high, then reads the fields back. A design that leaks the write changes the `lockCode` it reports. It sweeps the pin and the enable bit over array writes outside the region. A design that lets the hardware lock gate the array denies writes that should be granted. It also pulses each reset on its own. A design whose power-on reset wipes the register fields loses the lock code.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int ADDR_W          = 13;
  localparam int DATA_W          = 8;
  localparam int CODE_W          = 3;
  localparam int WD_W            = 2;
  localparam int FIXED_N         = 4;
  localparam int FIXED_BASE_LOG2 = 6;
  localparam int CODE_LSB        = 0;
  localparam int WD_LSB          = 3;
  localparam int WPE_BIT         = 7;
  localparam logic [WD_W-1:0] WD_DEFAULT = 2'b11;

  typedef enum logic [1:0] {
    REQ_ARRAY     = 2'b00,
    REQ_CTRL      = 2'b01,
    REQ_LATCH_SET = 2'b10,
    REQ_LATCH_CLR = 2'b11
  } reqKind_t;

  typedef logic [CODE_W-1:0] lockCode_t;

  typedef struct packed {
    logic latchSet;
    logic latchClr;
    logic regLoad;
  } ctrlStrb_t;
endpackage

// File: rtl/bl_region_decode.sv
module bl_region_decode
  import bl_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  lockCode_t         code,
  input  logic [AW-1:0]     addr,
  output logic              inRegion
);
  logic [FIXED_N-1:0] inFixed;

  for (genvar k = 0; k < FIXED_N; k++) begin : g_fixed
    localparam int LOW = FIXED_BASE_LOG2 + k;
    assign inFixed[k] = &addr[AW-1:LOW];
  end

  always_comb begin
    unique case (code)
      3'b000:  inRegion = 1'b0;
      3'b001:  inRegion = &addr[AW-1:AW-2];
      3'b010:  inRegion = addr[AW-1];
      3'b011:  inRegion = 1'b1;
      default: inRegion = inFixed[code[1:0]];
    endcase
  end
endmodule

// File: rtl/bl_control.sv
module bl_control
  import bl_pkg::*;
(
  input  logic      clk,
  input  logic      nvClrN,
  input  logic      porN,
  input  logic      reqValid,
  input  reqKind_t  reqKind,
  input  logic      wpPin,
  input  logic      inRegion,
  input  logic      welQ,
  input  logic      wpeQ,
  input  lockCode_t lockQ,
  output ctrlStrb_t strb,
  output logic      respValid,
  output logic      respGrant
);
  logic hwLock;
  logic grantNext;

  assign hwLock = wpPin & wpeQ;

  always_comb begin
    grantNext = 1'b0;
    unique case (reqKind)
      REQ_ARRAY:     grantNext = !inRegion;
      REQ_CTRL:      grantNext = welQ && !hwLock;
      REQ_LATCH_SET: grantNext = 1'b1;
      REQ_LATCH_CLR: grantNext = 1'b1;
      default:       grantNext = 1'b0;
    endcase
  end

  always_comb begin
    strb.latchSet = reqValid && (reqKind == REQ_LATCH_SET);
    strb.latchClr = reqValid && (reqKind == REQ_LATCH_CLR);
    strb.regLoad  = reqValid && (reqKind == REQ_CTRL) && grantNext;
  end

  always_ff @(posedge clk or negedge porN or negedge nvClrN) begin
    if (!porN || !nvClrN) begin
      respValid <= 1'b0;
      respGrant <= 1'b0;
    end else begin
      respValid <= reqValid;
      respGrant <= reqValid && grantNext;
    end
  end

  // R2: one answer per request, none without one
  p_resp_follow_r2: assert property (@(posedge clk) disable iff (!porN || !nvClrN)
    reqValid |=> respValid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!porN || !nvClrN)
    !reqValid |=> !respValid);
  // R3: whole-array code denies every array write
  p_all_locked_r3: assert property (@(posedge clk) disable iff (!porN || !nvClrN)
    (reqValid && reqKind == REQ_ARRAY && lockQ == 3'b011) |=> !respGrant);
  // R6: latch commands always succeed
  p_latch_cmd_r6: assert property (@(posedge clk) disable iff (!porN || !nvClrN)
    (reqValid && (reqKind == REQ_LATCH_SET || reqKind == REQ_LATCH_CLR)) |=> respGrant);
  // R7: latch gates control writes
  p_latch_gate_r7: assert property (@(posedge clk) disable iff (!porN || !nvClrN)
    (reqValid && reqKind == REQ_CTRL && !welQ) |=> !respGrant);
  // R8: pin plus enable bit freezes the register
  p_hw_lock_r8: assert property (@(posedge clk) disable iff (!porN || !nvClrN)
    (reqValid && reqKind == REQ_CTRL && wpPin && wpeQ) |=> !respGrant);
endmodule

// File: rtl/bl_datapath.sv
module bl_datapath
  import bl_pkg::*;
(
  input  logic              clk,
  input  logic              nvClrN,
  input  logic              porN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] regData,
  output logic              welQ,
  output lockCode_t         lockQ,
  output logic [WD_W-1:0]   wdQ,
  output logic              wpeQ
);
  logic [1:0] unusedBits;
  assign unusedBits = regData[6:5];

  // nonvolatile fields: only the factory clear touches them
  always_ff @(posedge clk or negedge nvClrN) begin
    if (!nvClrN) begin
      lockQ <= '0;
      wdQ   <= WD_DEFAULT;
      wpeQ  <= 1'b0;
    end else if (strb.regLoad) begin
      lockQ <= regData[CODE_LSB +: CODE_W];
      wdQ   <= regData[WD_LSB +: WD_W];
      wpeQ  <= regData[WPE_BIT];
    end
  end

  // volatile latch: cleared by either reset
  always_ff @(posedge clk or negedge porN or negedge nvClrN) begin
    if (!porN || !nvClrN)   welQ <= 1'b0;
    else if (strb.latchSet) welQ <= 1'b1;
    else if (strb.latchClr) welQ <= 1'b0;
  end

  // R7 / R8: fields move only on a register load
  p_nv_hold_r7: assert property (@(posedge clk) disable iff (!nvClrN)
    !strb.regLoad |=> ($stable(lockQ) && $stable(wdQ) && $stable(wpeQ)));
  // R10: power-on reset leaves the latch clear
  p_wel_por_r10: assert property (@(posedge clk) disable iff (!nvClrN)
    !porN |-> !welQ);
endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import bl_pkg::*;
(
  input  logic              clk,
  input  logic              nvClrN,
  input  logic              porN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              wpPin,
  output logic              respValid,
  output logic              respGrant,
  output logic              wel,
  output logic [CODE_W-1:0] lockCode,
  output logic              wpEnable,
  output logic [WD_W-1:0]   wdSel
);
  ctrlStrb_t strb;
  reqKind_t  kind;
  logic      inRegion;
  lockCode_t lockQ;
  logic      welQ;
  logic      wpeQ;
  logic [WD_W-1:0] wdQ;

  assign kind = reqKind_t'(reqKind);

  bl_region_decode #(.AW(ADDR_W)) region_i (
    .code(lockQ), .addr(reqAddr), .inRegion(inRegion)
  );

  bl_control ctrl_i (
    .clk(clk), .nvClrN(nvClrN), .porN(porN), .reqValid(reqValid),
    .reqKind(kind), .wpPin(wpPin), .inRegion(inRegion), .welQ(welQ),
    .wpeQ(wpeQ), .lockQ(lockQ), .strb(strb),
    .respValid(respValid), .respGrant(respGrant)
  );

  bl_datapath dp_i (
    .clk(clk), .nvClrN(nvClrN), .porN(porN), .strb(strb), .regData(reqData),
    .welQ(welQ), .lockQ(lockQ), .wdQ(wdQ), .wpeQ(wpeQ)
  );

  assign wel      = welQ;
  assign lockCode = lockQ;
  assign wpEnable = wpeQ;
  assign wdSel    = wdQ;

  // R5: top-of-array addresses outside every region are never refused with code 000
  p_open_array_r5: assert property (@(posedge clk) disable iff (!porN || !nvClrN)
    (reqValid && reqKind == 2'b00 && lockCode == 3'b000) |=> respGrant);
endmodule

// File: tb/blk_lock_guard_tb_top.sv
`timescale 1ns/1ps
module blk_lock_guard_tb_top;
  logic clk = 0;
  logic nvClrN, porN, reqValid, wpPin;
  logic [1:0] reqKind;
  logic [12:0] reqAddr;
  logic [7:0] reqData;
  logic respValid, respGrant, wel, wpEnable;
  logic [2:0] lockCode;
  logic [1:0] wdSel;

  int nChecks = 0, nFails = 0;
  logic expQ[$];
  string tagQ[$];

  // bench model of the register state
  int mLock = 0, mWd = 3, mWpe = 0, mWel = 0;

  always #2.5 clk = ~clk;

  blk_lock_guard dut_i (
    .clk(clk), .nvClrN(nvClrN), .porN(porN), .reqValid(reqValid),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqData(reqData), .wpPin(wpPin),
    .respValid(respValid), .respGrant(respGrant), .wel(wel),
    .lockCode(lockCode), .wpEnable(wpEnable), .wdSel(wdSel)
  );

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit expLocked(int code, int addr);
    int lim;
    case (code)
      0: return 0;
      1: lim = 8192 * 3 / 4;
      2: lim = 8192 / 2;
      3: lim = 0;
      default: lim = 8192 - (64 << (code - 4));
    endcase
    return addr >= lim;
  endfunction

  // monitor: pop expected grants as responses appear
  always @(negedge clk) begin
    if (porN && nvClrN && respValid) begin
      if (expQ.size() == 0) check("R2 unexpected response", 1, 0);
      else begin
        automatic logic e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, int'(respGrant), int'(e));
      end
    end
  end

  task automatic doReq(int kind, int addr, int data, bit wp, string tag);
    bit g;
    @(negedge clk);
    reqValid = 1; reqKind = kind[1:0]; reqAddr = addr[12:0];
    reqData = data[7:0]; wpPin = wp;
    case (kind)
      0: g = !expLocked(mLock, addr);
      1: g = (mWel == 1) && !(wp && mWpe == 1);
      default: g = 1;
    endcase
    expQ.push_back(g);
    tagQ.push_back(tag);
    if (kind == 2) mWel = 1;
    if (kind == 3) mWel = 0;
    if (kind == 1 && g) begin
      mLock = data & 7; mWd = (data >> 3) & 3; mWpe = (data >> 7) & 1;
    end
    @(negedge clk);
    reqValid = 0; wpPin = 0;
  endtask

  task automatic checkState(string tag);
    check({tag, " lockCode"}, int'(lockCode), mLock);
    check({tag, " wdSel"}, int'(wdSel), mWd);
    check({tag, " wpEnable"}, int'(wpEnable), mWpe);
    check({tag, " wel"}, int'(wel), mWel);
  endtask

  bit done = 0;

  initial begin
    nvClrN = 0; porN = 0; reqValid = 0; reqKind = 0; reqAddr = 0;
    reqData = 0; wpPin = 0;
    repeat (3) @(negedge clk);
    checkState("R1 reset");
    check("R1 respValid in reset", int'(respValid), 0);
    nvClrN = 1; porN = 1;
    @(negedge clk);
    check("R2 idle no response", int'(respValid), 0);

    doReq(0, 8191, 0, 0, "R3 code000 top address granted");
    doReq(1, 0, 8'h03, 0, "R7 ctrl write with latch clear");
    checkState("R7 fields unchanged");
    doReq(2, 0, 0, 0, "R6 latch set");
    checkState("R6 latch set");
    doReq(1, 0, 8'h13, 0, "R9 ctrl write code011");
    checkState("R9 fields loaded");
    doReq(0, 0, 0, 0, "R3 whole array address 0");
    doReq(0, 8191, 0, 1, "R3 whole array top");

    // fractional and fixed codes at their boundaries
    for (int c = 1; c < 8; c++) begin
      int lim;
      if (c == 3) continue;
      doReq(1, 0, c | 8'h18, 0, "R9 load code");
      case (c)
        1: lim = 6144;
        2: lim = 4096;
        default: lim = 8192 - (64 << (c - 4));
      endcase
      doReq(0, lim, 0, 0, (c < 4) ? "R3 boundary denied" : "R4 boundary denied");
      doReq(0, lim - 1, 0, 0, (c < 4) ? "R3 below boundary granted" : "R4 below boundary granted");
    end
    checkState("R9 after sweep");

    // hardware lock: set enable bit with code 100
    doReq(1, 0, 8'h84, 0, "R8 ctrl write wp low granted");
    checkState("R8 enable set");
    for (int w = 0; w < 2; w++)
      doReq(0, 100, 0, w[0], "R5 outside region any wp");
    doReq(1, 0, 8'h03, 1, "R8 ctrl write frozen");
    checkState("R8 fields unchanged");
    doReq(1, 0, 8'h05, 0, "R8 ctrl write wp low again");
    checkState("R8 fields updated");
    doReq(0, 8191, 0, 1, "R4 fixed region wp high");

    doReq(3, 0, 0, 0, "R6 latch clear");
    doReq(1, 0, 8'h00, 0, "R7 ctrl denied after clear");
    checkState("R7 state");

    // power cycle keeps the register
    doReq(2, 0, 0, 0, "R6 latch set again");
    @(negedge clk); porN = 0;
    @(negedge clk); porN = 1;
    mWel = 0;
    @(negedge clk);
    checkState("R10 after power-on reset");

    // factory clear
    @(negedge clk); nvClrN = 0;
    mLock = 0; mWd = 3; mWpe = 0; mWel = 0;
    @(negedge clk);
    checkState("R1 factory clear");
    nvClrN = 1;
    @(negedge clk);
    check("R2 queue drained", expQ.size(), 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule